// File: doc/BRIEF.md
# Display FIFO Refill Threshold Calculator

This block works out the timing words for a display FIFO. Pixels drain the FIFO on the pixel clock, and memory refills it on a separate memory clock. From the clock-synthesis divider settings, the pixel depth and the memory delays, the block computes four results. The first is a fixed-point precision exponent. The second is the FIFO level at which refill stops. The third is the level at which refill starts. The fourth is the number of memory clocks per 64-bit quadword. It packs these results into two 32-bit words that a display controller can load.

The caller presents the parameters and pulses `start` for one cycle. The block captures the parameters, strips common factors of two from its ratio operands and runs five divisions through one shared restoring divider. It then rounds and, when needed, corrects the start threshold. `done` pulses for one cycle when both words are valid. The words hold their values until the next `done`.

Top module: `fifo_refill_calc`

## Requirements
- R1: The ratio operands are M = mclk_fb × vclk_post and D = vclk_fb × xclk_ref. D is also multiplied by (bpp >> 2) when bpp ≥ 8. While M and D are both even and not both zero, both are halved. Every later step uses the halved pair.
- R2: The base shift is s0 = 4 − xclk_post, less one more when bpp = 0. The off threshold is floor(sh(M × (fifo_depth − 1), s2) / D) − 2^s0. It is taken modulo 2^32 and placed in onoff_word[15:0].
- R3: P is the bit length of floor(sh(M × fifo_depth, s0) / D), minus 5, clamped to 0..7. P appears in cfg_word[22:20], and cfg_word[31:23] are zero. The exponent shift is x = 6 − P, and s2 = s0 + x. The function sh(v, n) shifts v left by n when n ≥ 0 and right by −n when n < 0.
- R4: The on threshold starts at floor((sh(M, s2) + D) / D). If it is below r = sh(ras_dly, x) + 1, it is raised to r. Then 2r + sh(pf_dly, x) is added.
- R5: With k = 7 − P, the granule is G = 2^(k−1) for k ≥ 1, and G = 1 for k = 0. The on threshold is rounded up to a multiple of G.
- R6: The rounded on threshold may be greater than or equal to the off threshold rounded down to a multiple of G. In that case the on threshold is replaced by (off − floor(sh(M, s2) / D)) modulo 2^32, rounded down to a multiple of G. The result is placed in onoff_word[31:16].
- R7: cfg_word[15:0] holds floor((sh(M, s2 + 5) + D) / D) modulo 2^16. cfg_word[19:16] holds loop_lat.
- R8: After a `start` seen while idle, `busy` is high from the next cycle until `done`. `done` is a one-cycle pulse. cfg_word and onoff_word change only in the cycle `done` is high.
- R9: A `start` pulse while `busy` is high is ignored. The run in progress finishes with the parameters it captured.
- R10: After reset, busy, done, cfg_word and onoff_word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to compute |
| mclk_fb | input | 8 | Memory clock feedback divider |
| vclk_fb | input | 8 | Pixel clock feedback divider (nonzero) |
| vclk_post | input | 4 | Pixel clock post divide value (nonzero) |
| xclk_ref | input | 2 | Memory clock reference divide (1 or 3) |
| xclk_post | input | 2 | Memory clock post divide code |
| bpp | input | 6 | Bits per pixel, 0 for text mode |
| fifo_depth | input | 6 | FIFO depth in quadwords (at least 2) |
| ras_dly | input | 5 | RAS delay in memory clocks |
| pf_dly | input | 5 | Page-fault delay in memory clocks |
| loop_lat | input | 4 | Loop latency field |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Results valid pulse |
| cfg_word | output | 32 | Precision, latency and clocks-per-quadword word |
| onoff_word | output | 32 | On and off threshold word |

## Verification
The results appear a data-dependent number of cycles after `start`. That number is a few normalization cycles plus five divisions of about fifty cycles each. So the bench waits for the `done` pulse, with a bound on the wait, instead of counting a fixed delay. It samples `busy` on the falling edge one cycle after `start`. It compares both words on the falling edge of the `done` cycle and confirms that `done` has dropped one cycle later. A second `start` is sent in the middle of a run. The words that come out must then still belong to the first parameter set.

// File: rtl/fcalc_pkg.sv
package fcalc_pkg;
    localparam int WIDE  = 48;
    localparam int OPW   = 16;
    localparam int PMAX  = 7;
    localparam int PBIAS = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_NORM, ST_TMP, ST_OFF, ST_ON, ST_STEP, ST_XCK, ST_FIN
    } st_e;

    typedef struct packed {
        logic [7:0] mfb;
        logic [7:0] vfb;
        logic [3:0] vpost;
        logic [1:0] xref;
        logic [1:0] xpost;
        logic [5:0] bpp;
        logic [5:0] fifo;
        logic [4:0] ras;
        logic [4:0] pf;
        logic [3:0] lat;
    } req_t;

    function automatic logic [WIDE-1:0] sshl(input logic [WIDE-1:0] v,
                                             input logic signed [6:0] s);
        logic [6:0] n;
        if (s[6]) begin
            n = 7'(-s);
            return v >> n;
        end
        n = 7'(s);
        return v << n;
    endfunction

    function automatic logic [6:0] bitlen(input logic [WIDE-1:0] v);
        logic [6:0] n;
        n = '0;
        for (int i = 0; i < WIDE; i++)
            if (v[i]) n = 7'(i + 1);
        return n;
    endfunction

    function automatic logic [2:0] prec_of(input logic [6:0] len);
        if (len <= 7'(PBIAS)) return 3'd0;
        if (len >= 7'(PBIAS + PMAX)) return 3'(PMAX);
        return 3'(len - 7'(PBIAS));
    endfunction
endpackage

// File: rtl/fcalc_norm.sv
module fcalc_norm #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         settled
);
    logic [W-1:0] both;
    assign both    = a_out | b_out;
    assign settled = both[0] || (both == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_out <= '0;
            b_out <= '0;
        end else if (load) begin
            a_out <= a_in;
            b_out <= b_in;
        end else if (!settled) begin
            a_out <= a_out >> 1;
            b_out <= b_out >> 1;
        end
    end

    // R1: once the pair is settled and no new load arrives, it must not move
    p_norm_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (settled && !load) |=> $stable(a_out) && $stable(b_out));
endmodule

// File: rtl/fcalc_div.sv
module fcalc_div #(
    parameter int DW = 48,
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic [DW-1:0] quo,
    output logic          done
);
    localparam int CW = $clog2(DW + 1);

    logic [VW-1:0] rem;
    logic [VW-1:0] dvs;
    logic [CW-1:0] cnt;
    logic          run;
    logic [VW:0]   sh;

    assign sh = {rem, quo[DW-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            dvs  <= '0;
            quo  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !run) begin
                quo <= dividend;
                dvs <= divisor;
                rem <= '0;
                cnt <= CW'(DW);
                run <= 1'b1;
            end else if (run) begin
                if (sh >= {1'b0, dvs}) begin
                    rem <= VW'(sh - {1'b0, dvs});
                    quo <= {quo[DW-2:0], 1'b1};
                end else begin
                    rem <= sh[VW-1:0];
                    quo <= {quo[DW-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R8: the divider completion strobe lasts one cycle
    p_div_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/fcalc_onthr.sv
module fcalc_onthr
    import fcalc_pkg::*;
(
    input  logic [31:0]       on_q,
    input  logic [31:0]       off,
    input  logic [31:0]       step,
    input  logic [4:0]        ras,
    input  logic [4:0]        pf,
    input  logic signed [6:0] xs,
    input  logic [2:0]        prec,
    output logic [31:0]       on_fin
);
    logic [31:0] r, a, a2, up, offd, mask, pfs;
    logic [2:0]  k, gl;

    always_comb begin
        r    = 32'(sshl(WIDE'(ras), xs)) + 32'd1;
        pfs  = 32'(sshl(WIDE'(pf), xs));
        a    = (on_q < r) ? r : on_q;
        a2   = a + (r << 1) + pfs;
        k    = 3'(PMAX) - prec;
        gl   = (k == 3'd0) ? 3'd0 : k - 3'd1;
        mask = (32'd1 << gl) - 32'd1;
        up   = (a2 + mask) & ~mask;
        offd = off & ~mask;
        if (up >= offd)
            on_fin = (off - step) & ~mask;
        else
            on_fin = up;
    end
endmodule

// File: rtl/fifo_refill_calc.sv
module fifo_refill_calc
    import fcalc_pkg::*;
#(
    parameter int DIVW = WIDE,
    parameter int OPNW = OPW
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  mclk_fb,
    input  logic [7:0]  vclk_fb,
    input  logic [3:0]  vclk_post,
    input  logic [1:0]  xclk_ref,
    input  logic [1:0]  xclk_post,
    input  logic [5:0]  bpp,
    input  logic [5:0]  fifo_depth,
    input  logic [4:0]  ras_dly,
    input  logic [4:0]  pf_dly,
    input  logic [3:0]  loop_lat,
    output logic        busy,
    output logic        done,
    output logic [31:0] cfg_word,
    output logic [31:0] onoff_word
);
    st_e   state;
    req_t  rq;
    logic  issued;
    logic [2:0]  prec_r;
    logic [31:0] off_r, onq_r, step_r, xck_r;

    // operand formation from live ports, captured by the normalizer at start
    logic [OPNW-1:0] m_raw, d_raw, m_n, d_n;
    logic [3:0]      bfac;
    logic            settled, accept;

    assign accept = start && (state == ST_IDLE);
    assign bfac   = (bpp >= 6'd8) ? bpp[5:2] : 4'd1;
    assign m_raw  = OPNW'(mclk_fb) * OPNW'(vclk_post);
    assign d_raw  = OPNW'(vclk_fb) * OPNW'(xclk_ref) * OPNW'(bfac);

    fcalc_norm #(.W(OPNW)) u_norm (
        .clk(clk), .rst(rst), .load(accept),
        .a_in(m_raw), .b_in(d_raw),
        .a_out(m_n), .b_out(d_n), .settled(settled)
    );

    // shift amounts
    logic signed [6:0] vs0, xs, vs2;
    assign vs0 = 7'sd4 - $signed({5'b0, rq.xpost}) - ((rq.bpp == '0) ? 7'sd1 : 7'sd0);
    assign xs  = 7'sd6 - $signed({4'b0, prec_r});
    assign vs2 = vs0 + xs;

    // dividend selection per step
    logic [DIVW-1:0] mw, dw, dividend, quo;
    logic            div_go, div_done, in_div;
    assign mw = DIVW'(m_n);
    assign dw = DIVW'(d_n);

    always_comb begin
        case (state)
            ST_TMP:  dividend = sshl(mw * DIVW'(rq.fifo), vs0);
            ST_OFF:  dividend = sshl(mw * DIVW'(rq.fifo - 6'd1), vs2);
            ST_ON:   dividend = sshl(mw, vs2) + dw;
            ST_STEP: dividend = sshl(mw, vs2);
            ST_XCK:  dividend = sshl(mw, vs2 + 7'sd5) + dw;
            default: dividend = '0;
        endcase
    end

    assign in_div = (state == ST_TMP) || (state == ST_OFF) || (state == ST_ON) ||
                    (state == ST_STEP) || (state == ST_XCK);
    assign div_go = in_div && !issued;

    fcalc_div #(.DW(DIVW), .VW(OPNW)) u_div (
        .clk(clk), .rst(rst), .go(div_go),
        .dividend(dividend), .divisor(d_n),
        .quo(quo), .done(div_done)
    );

    logic [31:0] on_fin;
    fcalc_onthr u_onthr (
        .on_q(onq_r), .off(off_r), .step(step_r),
        .ras(rq.ras), .pf(rq.pf), .xs(xs), .prec(prec_r),
        .on_fin(on_fin)
    );

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            rq         <= '0;
            issued     <= 1'b0;
            prec_r     <= '0;
            off_r      <= '0;
            onq_r      <= '0;
            step_r     <= '0;
            xck_r      <= '0;
            cfg_word   <= '0;
            onoff_word <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    rq    <= '{mfb: mclk_fb, vfb: vclk_fb, vpost: vclk_post,
                               xref: xclk_ref, xpost: xclk_post, bpp: bpp,
                               fifo: fifo_depth, ras: ras_dly, pf: pf_dly,
                               lat: loop_lat};
                    state <= ST_NORM;
                end
                ST_NORM: if (settled) state <= ST_TMP;
                ST_FIN: begin
                    cfg_word   <= {9'b0, prec_r, rq.lat, xck_r[15:0]};
                    onoff_word <= {on_fin[15:0], off_r[15:0]};
                    done       <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: begin
                    if (!issued) begin
                        issued <= 1'b1;
                    end else if (div_done) begin
                        issued <= 1'b0;
                        case (state)
                            ST_TMP: begin
                                prec_r <= prec_of(bitlen(quo));
                                state  <= ST_OFF;
                            end
                            ST_OFF: begin
                                off_r <= quo[31:0] - (32'd1 << vs0[2:0]);
                                state <= ST_ON;
                            end
                            ST_ON: begin
                                onq_r <= quo[31:0];
                                state <= ST_STEP;
                            end
                            ST_STEP: begin
                                step_r <= quo[31:0];
                                state  <= ST_XCK;
                            end
                            default: begin
                                xck_r <= quo[31:0];
                                state <= ST_FIN;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: an accepted start makes busy visible on the next cycle
    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R8: result words move only together with done
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(cfg_word) && $stable(onoff_word));
    // R9: a start while busy never interrupts a run
    p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !done) |=> busy || done);
    // R5: the published on threshold sits on the precision granule
    p_granule_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> ((onoff_word[31:16] &
                  16'((16'd1 << ((cfg_word[22:20] == 3'd7) ? 3'd0 :
                                 (3'd6 - cfg_word[22:20]))) - 16'd1)) == 16'd0));
endmodule

// File: tb/fifo_refill_calc_tb.sv
module fifo_refill_calc_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  mclk_fb = '0, vclk_fb = 8'd1;
    logic [3:0]  vclk_post = 4'd1;
    logic [1:0]  xclk_ref = 2'd1, xclk_post = '0;
    logic [5:0]  bpp = '0, fifo_depth = 6'd24;
    logic [4:0]  ras_dly = '0, pf_dly = '0;
    logic [3:0]  loop_lat = '0;
    logic        busy, done;
    logic [31:0] cfg_word, onoff_word;

    int checks = 0;
    int fails  = 0;
    bit hung   = 0;

    always #2 clk = ~clk;

    fifo_refill_calc u_dut (
        .clk(clk), .rst(rst), .start(start),
        .mclk_fb(mclk_fb), .vclk_fb(vclk_fb), .vclk_post(vclk_post),
        .xclk_ref(xclk_ref), .xclk_post(xclk_post), .bpp(bpp),
        .fifo_depth(fifo_depth), .ras_dly(ras_dly), .pf_dly(pf_dly),
        .loop_lat(loop_lat), .busy(busy), .done(done),
        .cfg_word(cfg_word), .onoff_word(onoff_word)
    );

    function automatic longint bs(longint v, int s);
        return (s < 0) ? (v >> (-s)) : (v << s);
    endfunction

    function automatic void model(input int mfb, vfb, vp, xr, xp, bp, ff,
                                  ras, pf, lat,
                                  output logic [31:0] cfg, output logic [31:0] oo);
        longint m, d, t, off, onv, r, mask, up, offd, xck;
        int s0, bl, p, x, s2, k, gl;
        m = mfb * vp;
        d = vfb * xr;
        if (bp >= 8) d = d * (bp >> 2);
        s0 = 4 - xp - ((bp == 0) ? 1 : 0);
        while (((m | d) & 1) == 0 && (m | d) != 0) begin
            m = m >> 1;
            d = d >> 1;
        end
        t = bs(m * ff, s0) / d;
        bl = 0;
        while (t != 0) begin
            t = t >> 1;
            bl++;
        end
        p = bl - 5;
        if (p < 0) p = 0;
        if (p > 7) p = 7;
        x = 6 - p;
        s2 = s0 + x;
        off = (bs(m * (ff - 1), s2) / d - (64'd1 << s0)) & 64'hFFFF_FFFF;
        onv = (bs(m, s2) + d) / d;
        r = bs(ras, x) + 1;
        if (onv < r) onv = r;
        onv = onv + 2 * r + bs(pf, x);
        k = 7 - p;
        gl = (k == 0) ? 0 : k - 1;
        mask = (64'd1 << gl) - 1;
        up = (onv + mask) & ~mask;
        offd = off & ~mask;
        if (up >= offd)
            onv = ((off - bs(m, s2) / d) & 64'hFFFF_FFFF) & ~mask;
        else
            onv = up;
        xck = (bs(m, s2 + 5) + d) / d;
        cfg = 32'((p << 20) | (lat << 16) | (xck & 64'hFFFF));
        oo  = 32'(((onv & 64'hFFFF) << 16) | (off & 64'hFFFF));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic apply(input int mfb, vfb, vp, xr, xp, bp, ff, ras, pf, lat);
        mclk_fb = 8'(mfb); vclk_fb = 8'(vfb); vclk_post = 4'(vp);
        xclk_ref = 2'(xr); xclk_post = 2'(xp); bpp = 6'(bp);
        fifo_depth = 6'(ff); ras_dly = 5'(ras); pf_dly = 5'(pf); loop_lat = 4'(lat);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            hung = 1;
            checks++;
            fails++;
            $display("FAIL R8: done never arrived, actual 0 expected 1");
        end
    endtask

    task automatic run_case(input int mfb, vfb, vp, xr, xp, bp, ff, ras, pf, lat);
        logic [31:0] ec, eo;
        model(mfb, vfb, vp, xr, xp, bp, ff, ras, pf, lat, ec, eo);
        @(negedge clk);
        apply(mfb, vfb, vp, xr, xp, bp, ff, ras, pf, lat);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 busy after start", 32'(busy), 32'd1);
        wait_done();
        if (hung) return;
        check("R1 R2 R3 R7 cfg_word", cfg_word, ec);
        check("R2 R4 R5 R6 onoff_word", onoff_word, eo);
        @(negedge clk);
        check("R8 done one cycle", 32'(done), 32'd0);
        check("R8 words held", cfg_word, ec);
    endtask

    initial begin
        int seed_dummy;
        logic [31:0] ec, eo;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 busy", 32'(busy), 32'd0);
        check("R10 done", 32'(done), 32'd0);
        check("R10 cfg_word", cfg_word, 32'd0);
        check("R10 onoff_word", onoff_word, 32'd0);

        // directed: precision clamped at 7 (R3)
        run_case(255, 1, 8, 1, 0, 4, 32, 3, 2, 9);
        // directed: precision clamped at 0, bpp factor applied (R1 R3)
        run_case(1, 255, 1, 3, 3, 32, 2, 0, 0, 5);
        // directed: text mode bpp 0 lowers base shift (R2)
        run_case(150, 120, 4, 1, 1, 0, 24, 4, 3, 8);
        // directed: large delays force the fallback path (R6)
        run_case(200, 100, 2, 1, 0, 16, 3, 31, 31, 11);
        // directed: both operands rich in factors of two (R1)
        run_case(128, 64, 8, 1, 2, 8, 32, 5, 4, 10);

        // R9: start during a run is ignored
        model(170, 140, 2, 1, 1, 16, 32, 6, 5, 8, ec, eo);
        @(negedge clk);
        apply(170, 140, 2, 1, 1, 16, 32, 6, 5, 8);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        apply(9, 200, 1, 3, 3, 24, 2, 30, 30, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        if (!hung) begin
            check("R9 cfg_word of first run", cfg_word, ec);
            check("R9 onoff_word of first run", onoff_word, eo);
            @(negedge clk);
            check("R9 idle after run", 32'(busy), 32'd0);
        end

        // constrained random
        for (int i = 0; i < 60 && !hung; i++) begin
            int vp, bp;
            case ($urandom % 5)
                0: vp = 1; 1: vp = 2; 2: vp = 4; 3: vp = 8; default: vp = 3;
            endcase
            case ($urandom % 6)
                0: bp = 0; 1: bp = 4; 2: bp = 8; 3: bp = 16; 4: bp = 24; default: bp = 32;
            endcase
            run_case(int'(128 + $urandom % 128), int'(128 + $urandom % 128), vp,
                     ($urandom % 2 == 0) ? 1 : 3, int'($urandom % 4), bp,
                     ($urandom % 2 == 0) ? 24 : 32, int'($urandom % 8),
                     int'($urandom % 8), int'($urandom % 16));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule